// File: doc/BRIEF.md
# Chainable Serial Command and Status Port for a Six-Channel Bridge Controller

This block is the serial front end of a six-channel half-bridge controller. A host acts as master over a four-wire serial link: select (active low), serial clock, data in and data out. During each frame the port takes in a 16-bit command word most significant bit first, and shifts out a 16-bit status word. The status word is a copy taken when the previous frame closed. A command becomes active only if the frame length is legal. A legal frame is the first 16-bit word plus any whole number of further 8-bit groups. This rule lets the device share one select line with 8-bit and 16-bit neighbours in a daisy chain. In a longer frame only the final 16 bits are kept. Bits received beyond the first 16 leave the data output 16 clocks later, so they reach the next device in the chain.

The serial clock, select and data in are oversampled by a fast system clock through synchronizers, and their edges are detected in that clock domain. The data output does not wait for a clock. From the moment select falls until the first rising serial-clock edge, it carries a thermal-shutdown flag ORed with data in. A shutdown anywhere in the chain therefore reaches the host at the very start of a frame. A committed word whose top bit is set also produces a one-cycle status-clear strobe. The shown status is then reset to zero.

Top module: `hb_spi_link`

## Requirements
- R1: While `rst_n` is low or `enable_i` is low, the committed command is zero, the clear strobe is low and the status copy is zero.
- R2: `sdo_oe_o` is high only while `sel_n_i` is low and `enable_i` is high. Otherwise the data output is disabled.
- R3: From a falling edge of `sel_n_i` until the first rising `sck_i` edge of that frame, `sdo_o` equals `therm_latched_i` OR `sdi_i`.
- R4: After rising edge k (k = 1..16) of a frame, `sdo_o` carries bit 16-k of the status copy. Status layout: bit 15 latched overcurrent, bit 14 supply fault, bit 13 underload, bits 12..1 six 2-bit channel fields with channel 6 in bits 12..11, bit 0 thermal warning.
- R5: After rising edge k with k > 16, `sdo_o` carries the data-in bit sampled at falling edge k-16.
- R6: Data in is sampled on falling `sck_i` edges and enters the word most significant bit first. Command layout: bit 15 status clear, bit 14 group select, bit 13 underload shutdown control, bits 12..7 enables for channels 6..1, bits 6..1 high-side selects for channels 6..1, bit 0 overvoltage lockout enable.
- R7: When select rises after a count of rising clock edges that is at least 16 and a multiple of 8, `cmd_o` takes the last 16 sampled bits.
- R8: Any other count (fewer than 16, or not a multiple of 8) leaves `cmd_o` unchanged and gives no clear strobe.
- R9: A committed word with bit 15 set raises `stat_clear_o` for exactly one system clock.
- R10: The status copy is loaded from `stat_i` each time select rises. It is loaded with zero instead if that frame committed a word with bit 15 set. The next frame shifts out this copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| enable_i | input | 1 | Device enable; low clears all state |
| sel_n_i | input | 1 | Frame select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| stat_i | input | 16 | Live status vector from the diagnostics |
| therm_latched_i | input | 1 | Latched thermal-shutdown flag |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data-out pad |
| cmd_o | output | 16 | Committed command word |
| stat_clear_o | output | 1 | One-cycle status-clear strobe |

## Verification
The select rising edge does two jobs in the same system clock. It decides whether to commit the command, and it reloads the status copy. When the committed word carries the clear bit, the reload must give zero instead of the live status. The bench provokes this with a legal frame whose last word has bit 15 set while `stat_i` is nonzero. It then judges the result in the next frame: the first 16 output bits must all be zero, and exactly one strobe must have appeared. A second collision is the pseudo-bit against the first rising edge. For that, data out is sampled before the first edge (flag OR data in) and after it (status MSB).

// File: rtl/hb_spi_link_pkg.sv
package hb_spi_link_pkg;

  // Events recovered from the oversampled serial pins.
  typedef struct packed {
    logic sel_lvl;
    logic sel_rise;
    logic sel_fall;
    logic sck_rise;
    logic sck_fall;
    logic sdi_lvl;
  } link_ev_t;

  // A frame is legal when it holds at least one full first word and then
  // only whole groups; a saturated counter makes any frame illegal.
  function automatic logic frame_len_ok(input int unsigned clocks,
                                        input logic        saturated,
                                        input int unsigned first_bits,
                                        input int unsigned group_bits);
    return !saturated && (clocks >= first_bits) && ((clocks % group_bits) == 0);
  endfunction

endpackage

// File: rtl/hb_sync_edge.sv
module hb_sync_edge #(
  parameter int              WIDTH     = 2,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  // STAGES synchronizer flops plus one history flop for edge detection.
  logic [WIDTH-1:0] stage_q [STAGES+1];

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RESET_VAL;
        else        stage_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RESET_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign lvl_o  = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~stage_q[STAGES];
  assign fall_o = ~stage_q[STAGES-1] & stage_q[STAGES];

endmodule

// File: rtl/hb_frame_counter.sv
module hb_frame_counter
  import hb_spi_link_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int FIRST_BITS = 16,
  parameter int GROUP_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic start_i,
  input  logic tick_i,
  output logic valid_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic             sat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      sat_q   <= 1'b0;
    end else if (clr_i || start_i) begin
      count_q <= '0;
      sat_q   <= 1'b0;
    end else if (tick_i) begin
      if (count_q == CNT_MAX) sat_q   <= 1'b1;
      else                    count_q <= count_q + 1'b1;
    end
  end

  assign valid_o = frame_len_ok(int'(count_q), sat_q, FIRST_BITS, GROUP_BITS);

endmodule

// File: rtl/hb_shift_core.sv
module hb_shift_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         sin_i,
  input  logic         idle_i,
  output logic [W-1:0] data_o,
  output logic         out_bit_o,
  output logic         started_o
);

  logic [W-1:0] sreg_q;
  logic         out_q;
  logic         started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q    <= '0;
      out_q     <= 1'b0;
      started_q <= 1'b0;
    end else if (clr_i) begin
      sreg_q    <= '0;
      out_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      // Shift register: status copy at frame start, received bits afterwards.
      if (load_i)      sreg_q <= load_val_i;
      else if (fall_i) sreg_q <= {sreg_q[W-2:0], sin_i};
      // Output bit advances on rising clock edges; the oldest bit leaves first.
      if (idle_i) begin
        started_q <= 1'b0;
      end else if (rise_i) begin
        started_q <= 1'b1;
        out_q     <= sreg_q[W-1];
      end
    end
  end

  assign data_o    = sreg_q;
  assign out_bit_o = out_q;
  assign started_o = started_q;

endmodule

// File: rtl/hb_spi_link.sv
module hb_spi_link
  import hb_spi_link_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int GROUP_W     = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              sel_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] stat_i,
  input  logic              therm_latched_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic              stat_clear_o
);

  localparam int       CLR_BIT  = WORD_W - 1;
  localparam int       PIN_N    = 3;
  localparam int       PIN_SEL  = 0;
  localparam int       PIN_SCK  = 1;
  localparam int       PIN_SDI  = 2;
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b001;

  logic [PIN_N-1:0] pin_lvl, pin_rise, pin_fall;
  link_ev_t         ev;
  logic             frame_valid;
  logic [WORD_W-1:0] shift_data;
  logic             out_bit, started;
  logic [WORD_W-1:0] snap_q;
  logic [WORD_W-1:0] cmd_q;
  logic             clear_q;
  logic             clr_all;

  // Named internal events, visible to the bound checker.
  logic             commit_ev;
  logic             commit_clear;

  hb_sync_edge #(
    .WIDTH    (PIN_N),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(PIN_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({sdi_i, sck_i, sel_n_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  always_comb begin
    ev.sel_lvl  = pin_lvl[PIN_SEL];
    ev.sel_rise = pin_rise[PIN_SEL];
    ev.sel_fall = pin_fall[PIN_SEL];
    ev.sck_rise = pin_rise[PIN_SCK] & ~pin_lvl[PIN_SEL];
    ev.sck_fall = pin_fall[PIN_SCK] & ~pin_lvl[PIN_SEL];
    ev.sdi_lvl  = pin_lvl[PIN_SDI];
  end

  logic unused_sync;
  assign unused_sync = &{pin_lvl[PIN_SCK], pin_rise[PIN_SDI], pin_fall[PIN_SDI]};

  assign clr_all = ~enable_i;

  hb_frame_counter #(
    .CNT_W     (CNT_W),
    .FIRST_BITS(WORD_W),
    .GROUP_BITS(GROUP_W)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_all),
    .start_i(ev.sel_fall),
    .tick_i (ev.sck_rise),
    .valid_o(frame_valid)
  );

  hb_shift_core #(
    .W(WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_all),
    .load_i    (ev.sel_fall),
    .load_val_i(snap_q),
    .rise_i    (ev.sck_rise),
    .fall_i    (ev.sck_fall),
    .sin_i     (ev.sdi_lvl),
    .idle_i    (ev.sel_lvl),
    .data_o    (shift_data),
    .out_bit_o (out_bit),
    .started_o (started)
  );

  assign commit_ev    = ev.sel_rise & enable_i & frame_valid;
  assign commit_clear = commit_ev & shift_data[CLR_BIT];

  // Command register, status copy and clear strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      snap_q  <= '0;
      clear_q <= 1'b0;
    end else if (clr_all) begin
      cmd_q   <= '0;
      snap_q  <= '0;
      clear_q <= 1'b0;
    end else begin
      clear_q <= commit_clear;
      if (commit_ev)   cmd_q  <= shift_data;
      if (ev.sel_rise) snap_q <= commit_clear ? '0 : stat_i;
    end
  end

  // Data out: pseudo-bit until the first clock of the frame, then shift data.
  assign sdo_oe_o     = enable_i & ~sel_n_i;
  assign sdo_o        = !sdo_oe_o ? 1'b0 :
                        (started ? out_bit : (therm_latched_i | sdi_i));
  assign cmd_o        = cmd_q;
  assign stat_clear_o = clear_q;

endmodule

// File: rtl/hb_spi_link_checker.sv
module hb_spi_link_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable_i,
  input logic [WORD_W-1:0] cmd_o,
  input logic              stat_clear_o,
  input logic              commit_ev
);

  // A strobe always comes with a committed word whose top bit is set.
  assert_strobe_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clear_o |-> cmd_o[WORD_W-1]);

  // The strobe lasts exactly one cycle.
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clear_o |=> !stat_clear_o);

  // The command only moves on a commit or on a disable.
  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_o) |-> ($past(commit_ev) || !$past(enable_i)));

  // Disable clears the command and the strobe.
  assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (cmd_o == '0) && !stat_clear_o);

endmodule

bind hb_spi_link hb_spi_link_checker #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable_i    (enable_i),
  .cmd_o       (cmd_o),
  .stat_clear_o(stat_clear_o),
  .commit_ev   (commit_ev)
);

// File: tb/hb_spi_link_bench.sv
module hb_spi_link_bench;

  localparam time HP = 200ns;   // half of a serial phase
  localparam int  NV = 11;

  typedef struct packed {
    logic [7:0]  nbits;
    logic [39:0] bits;   // right-aligned, sent MSB first
    logic [15:0] stat;
    logic        therm;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'd16, 40'h0000000002, 16'hA5C3, 1'b0},
    '{8'd16, 40'h0000001F80, 16'h1234, 1'b1},
    '{8'd24, 40'h0000AB7E41, 16'h0F0F, 1'b0},
    '{8'd12, 40'h0000000FFF, 16'hBEEF, 1'b0},
    '{8'd20, 40'h00000ABCDE, 16'h5A5A, 1'b1},
    '{8'd32, 40'h0013572468, 16'hC001, 1'b0},
    '{8'd17, 40'h0000013579, 16'h7777, 1'b0},
    '{8'd40, 40'h1234567001, 16'h8421, 1'b0},
    '{8'd16, 40'h000000F001, 16'h3C3C, 1'b0},
    '{8'd8,  40'h00000000AA, 16'h6E6E, 1'b1},
    '{8'd16, 40'h0000000055, 16'h0101, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b1;
  logic        sel_n_i = 1'b1;
  logic        sck_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic [15:0] stat_i = '0;
  logic        therm_latched_i = 1'b0;
  logic        sdo_o, sdo_oe_o, stat_clear_o;
  logic [15:0] cmd_o;

  int          checks = 0;
  int          fails = 0;
  int          clr_seen = 0;
  logic        done = 1'b0;
  logic [15:0] snap_m = '0;
  logic [15:0] cmd_m = '0;

  always #10ns clk = ~clk;

  always @(posedge clk) if (stat_clear_o) clr_seen <= clr_seen + 1;

  hb_spi_link u_hb_spi_link (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (enable_i),
    .sel_n_i        (sel_n_i),
    .sck_i          (sck_i),
    .sdi_i          (sdi_i),
    .stat_i         (stat_i),
    .therm_latched_i(therm_latched_i),
    .sdo_o          (sdo_o),
    .sdo_oe_o       (sdo_oe_o),
    .cmd_o          (cmd_o),
    .stat_clear_o   (stat_clear_o)
  );

  task automatic chk(input logic ok, input string req,
                     input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One frame of n clocks; expectations follow the requirements.
  task automatic run_frame(input int n, input logic [39:0] bits, input logic th);
    int   clr_before;
    logic legal;
    logic expb;
    clr_before      = clr_seen;
    therm_latched_i = th;
    sdi_i           = 1'b0;
    sel_n_i         = 1'b0;
    #(HP);
    chk(sdo_oe_o == 1'b1, "R2 oe in frame", 40'(sdo_oe_o), 40'd1);
    chk(sdo_o == th, "R3 pseudo-bit", 40'(sdo_o), 40'(th));
    for (int i = 0; i < n; i++) begin
      sdi_i = bits[n-1-i];
      #(HP/2);
      sck_i = 1'b1;
      #(HP/2);
      if (i < 16) begin
        expb = snap_m[15-i];
        chk(sdo_o == expb, "R4 R10 status bit", 40'(sdo_o), 40'(expb));
      end else begin
        expb = bits[n-1-(i-16)];
        chk(sdo_o == expb, "R5 pass-through bit", 40'(sdo_o), 40'(expb));
      end
      #(HP/2);
      sck_i = 1'b0;
      #(HP/2);
    end
    #(HP);
    sel_n_i = 1'b1;
    sdi_i   = 1'b0;
    #(2*HP);
    legal = (n >= 16) && (n % 8 == 0);
    if (legal) cmd_m = bits[15:0];
    if (legal) chk(cmd_o == cmd_m, "R6 R7 commit", 40'(cmd_o), 40'(cmd_m));
    else       chk(cmd_o == cmd_m, "R8 frame error keeps", 40'(cmd_o), 40'(cmd_m));
    chk(clr_seen - clr_before == ((legal && bits[15]) ? 1 : 0), "R9 strobe count",
        40'(clr_seen - clr_before), 40'((legal && bits[15]) ? 1 : 0));
    chk(sdo_oe_o == 1'b0, "R2 oe idle", 40'(sdo_oe_o), 40'd0);
    snap_m = (legal && bits[15]) ? 16'h0000 : stat_i;
  endtask

  initial begin
    #3ns;
    #100ns;
    chk(cmd_o == 16'h0 && stat_clear_o == 1'b0, "R1 reset state", 40'(cmd_o), 40'd0);
    chk(sdo_oe_o == 1'b0 && sdo_o == 1'b0, "R2 reset oe", 40'({sdo_oe_o, sdo_o}), 40'd0);
    rst_n = 1'b1;
    #(HP);

    for (int v = 0; v < NV; v++) begin
      stat_i = VECS[v].stat;
      run_frame(int'(VECS[v].nbits), VECS[v].bits, VECS[v].therm);
    end

    // R3: pseudo-bit follows data in when the flag is clear; no clocks = error.
    therm_latched_i = 1'b0;
    stat_i  = 16'h9999;
    sdi_i   = 1'b1;
    sel_n_i = 1'b0;
    #(HP);
    chk(sdo_o == 1'b1, "R3 data-in OR", 40'(sdo_o), 40'd1);
    sdi_i = 1'b0;
    #(HP/2);
    chk(sdo_o == 1'b0, "R3 data-in low", 40'(sdo_o), 40'd0);
    sel_n_i = 1'b1;
    #(2*HP);
    chk(cmd_o == cmd_m, "R8 empty frame", 40'(cmd_o), 40'(cmd_m));
    snap_m = stat_i;

    // R1/R2: disable clears state and gates the output even inside a frame.
    sel_n_i  = 1'b0;
    enable_i = 1'b0;
    #(HP);
    chk(sdo_oe_o == 1'b0, "R2 disabled oe", 40'(sdo_oe_o), 40'd0);
    chk(cmd_o == 16'h0, "R1 disable clears", 40'(cmd_o), 40'd0);
    sel_n_i  = 1'b1;
    #(HP);
    enable_i = 1'b1;
    cmd_m    = 16'h0;
    snap_m   = 16'h0;
    #(HP);
    stat_i = 16'h4242;
    run_frame(16, 40'h0000000300, 1'b0);   // R10: copy is zero after disable
    run_frame(16, 40'h0000000300, 1'b0);   // R10: copy now shows 0x4242

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule